// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of timer channels and the interrupt fabric. Each channel issues one-cycle fire and clear strobes together with its static configuration: enable, level or edge type, a 5-bit line index, a message-delivery enable and a 64-bit message descriptor. Depending on that configuration, a fire either holds an interrupt line asserted and sets a status bit, emits a one-clock pulse, or queues a 32-bit memory-write message. Line levels are formed from the registered channel state, so the output follows a fire by one clock.

A replacement mode takes lines 0 and 8 away from two external sources, a periodic interval timer input and a real-time-clock input. In that mode channel 0 drives line 0 and channel 1 drives line 8, whatever their index fields hold. The block also drives an enable output that turns off the external interval timer. Outside the mode the external inputs are forwarded to those two lines. Lines from index 16 upward are active-low.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset every line is deasserted (lines 0..15 low, lines 16..31 high), all status bits are 0, `msg_valid_o` is 0 and `pit_en_o` is 1.
- R2: An enabled level-type channel that fires sets its status bit and holds its line asserted from the next clock until it is cleared or disabled.
- R3: An enabled edge-type channel that fires leaves its status bit at 0 and asserts its line for exactly one clock.
- R4: A clear strobe, a fire while the channel enable or the global enable is 0, or either enable dropping, clears the status bit and releases a held line. A clear in the same cycle as a fire wins.
- R5: A line with index 16 or above is driven low when asserted and high when deasserted; lines below 16 are driven high when asserted.
- R6: A channel drives the line whose index is its 5-bit route field. While replacement mode is active, channel 0 drives line 0 and channel 1 drives line 8 regardless of their route fields.
- R7: A fire on an enabled channel with message delivery on drives no line, leaves the status bit unchanged, and queues a write whose address is descriptor bits 63:32 and whose data is descriptor bits 31:0.
- R8: A queued write appears on `msg_valid_o` one clock after it is queued at the earliest, and stays valid with stable address and data until `msg_ready_i` is high at a clock edge. Among waiting channels the lowest index is served first, and repeated fires of a channel that is still waiting yield one write.
- R9: Turning message delivery on for a channel clears its status bit and releases its held line.
- R10: Outside replacement mode, each change of `pit_i` appears on line 0 and the level of `rtc_i` appears on line 8, one clock later. `rtc_i` is sampled every clock, including in replacement mode.
- R11: Entering replacement mode drives `pit_en_o` low and removes both external sources from lines 0 and 8. Leaving it drives `pit_en_o` high, restores line 8 to the sampled RTC level, and keeps line 0 low until `pit_i` next changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Replacement mode select |
| fire_i | input | N_CH | Per-channel fire strobe |
| clear_i | input | N_CH | Per-channel clear strobe |
| ch_en_i | input | N_CH | Per-channel enable |
| ch_level_i | input | N_CH | 1 = level type, 0 = edge type |
| ch_msg_en_i | input | N_CH | Per-channel message delivery enable |
| ch_route_i | input | N_CH x 5 | Per-channel line index |
| ch_msg_desc_i | input | N_CH x 64 | Message descriptor: 63:32 address, 31:0 data |
| pit_i | input | 1 | External interval timer level |
| rtc_i | input | 1 | External real-time-clock level |
| msg_ready_i | input | 1 | Message sink ready |
| irq_o | output | N_LINES | Interrupt lines, polarity per R5 |
| status_o | output | N_CH | Level status bits |
| pit_en_o | output | 1 | Interval timer enable |
| msg_valid_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The hardest situation to reach is one where message arbitration, a blocked sink and repeated fires all meet: two channels must be waiting while the output slot is held by a stalled request, and then one of them must fire again before it is served. The stimulus holds `msg_ready_i` low, fires two channels together to observe lowest-first order, and then refires a waiting channel twice before releasing ready to show the merge. The entry into and exit from replacement mode are driven while channels hold lines 0 and 8 and the RTC level has changed underneath, so both the override and the restore are observed on the lines.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t addr;
    word_t data;
  } msg_t;
endpackage

// File: rtl/tmr_irq_chan.sv
`timescale 1ns/1ps
module tmr_irq_chan #(
  parameter int RW        = 5,
  parameter bit LEG_EN    = 1'b0,
  parameter int LEG_ROUTE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          glb_en_i,
  input  logic          legacy_i,
  input  logic          fire_i,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic          level_i,
  input  logic          msg_en_i,
  input  logic [RW-1:0] route_i,
  output logic          held_o,
  output logic          pulse_o,
  output logic          msg_fire_o,
  output logic [RW-1:0] route_eff_o
);
  logic st_q, pulse_q, msg_q;
  logic act, msg_rise, drop, take;

  assign act      = en_i & glb_en_i;
  assign msg_rise = msg_en_i & ~msg_q;
  assign drop     = clear_i | ~act | msg_rise;
  assign take     = fire_i & act & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= 1'b0;
      pulse_q <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      msg_q   <= msg_en_i;
      pulse_q <= take & ~msg_en_i & ~level_i;
      if (drop)                    st_q <= 1'b0;
      else if (take && !msg_en_i)  st_q <= level_i;
    end
  end

  assign msg_fire_o = take & msg_en_i;
  assign held_o     = st_q;
  assign pulse_o    = pulse_q;

  generate
    if (LEG_EN) begin : g_leg
      assign route_eff_o = legacy_i ? RW'(LEG_ROUTE) : route_i;
    end else begin : g_norm
      assign route_eff_o = route_i;
    end
  endgenerate

  a_r2_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && en_i && glb_en_i && !clear_i && !msg_en_i && level_i) |=> st_q);
  a_r4_disabled_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && glb_en_i) |=> !st_q);
  a_r3_edge_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !st_q);
  a_r9_msg_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_q |-> !st_q);
endmodule

// File: rtl/tmr_irq_msg_arb.sv
`timescale 1ns/1ps
module tmr_irq_msg_arb
  import tmr_irq_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       fire_i,
  input  msg_t [N_CH-1:0]       desc_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output msg_t                  msg_o
);
  logic [N_CH-1:0] pend_q, grant;
  logic            valid_q, load;
  msg_t            msg_q, sel;

  // lowest pending index wins
  assign grant = pend_q & (~pend_q + N_CH'(1));
  assign load  = (~valid_q | ready_i) & (|pend_q);

  always_comb begin
    sel = '0;
    for (int c = 0; c < N_CH; c++)
      if (grant[c]) sel = sel | desc_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~(load ? grant : '0)) | fire_i;
      if (load) begin
        valid_q <= 1'b1;
        msg_q   <= sel;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(msg_q)));
  a_r8_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

// File: rtl/tmr_irq_legacy.sv
`timescale 1ns/1ps
module tmr_irq_legacy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic legacy_i,
  input  logic pit_i,
  input  logic rtc_i,
  output logic legacy_o,
  output logic ext_a_o,
  output logic ext_b_o,
  output logic pit_en_o
);
  logic leg_q, rtc_q, pit_prev_q, pit_pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q      <= 1'b0;
      rtc_q      <= 1'b0;
      pit_prev_q <= 1'b0;
      pit_pass_q <= 1'b0;
    end else begin
      leg_q      <= legacy_i;
      rtc_q      <= rtc_i;
      pit_prev_q <= pit_i;
      // forwarded only on change; held low in and on leaving the mode
      if (legacy_i || leg_q)     pit_pass_q <= 1'b0;
      else if (pit_i != pit_prev_q) pit_pass_q <= pit_i;
    end
  end

  assign legacy_o = leg_q;
  assign ext_a_o  = ~leg_q & pit_pass_q;
  assign ext_b_o  = ~leg_q & rtc_q;
  assign pit_en_o = ~leg_q;

  a_r11_pit_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |=> !pit_en_o);
  a_r11_no_pit_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q |-> !pit_pass_q);
endmodule

// File: rtl/tmr_irq_router.sv
`timescale 1ns/1ps
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int N_CH       = 4,
  parameter int N_LINES    = 32,
  parameter int INV_BASE   = 16,
  parameter int LEG_LINE_A = 0,
  parameter int LEG_LINE_B = 8,
  localparam int RW        = $clog2(N_LINES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     glb_en_i,
  input  logic                     legacy_i,
  input  logic [N_CH-1:0]          fire_i,
  input  logic [N_CH-1:0]          clear_i,
  input  logic [N_CH-1:0]          ch_en_i,
  input  logic [N_CH-1:0]          ch_level_i,
  input  logic [N_CH-1:0]          ch_msg_en_i,
  input  logic [N_CH-1:0][RW-1:0]  ch_route_i,
  input  logic [N_CH-1:0][63:0]    ch_msg_desc_i,
  input  logic                     pit_i,
  input  logic                     rtc_i,
  input  logic                     msg_ready_i,
  output logic [N_LINES-1:0]       irq_o,
  output logic [N_CH-1:0]          status_o,
  output logic                     pit_en_o,
  output logic                     msg_valid_o,
  output logic [WORD_W-1:0]        msg_addr_o,
  output logic [WORD_W-1:0]        msg_data_o
);
  localparam logic [N_LINES-1:0] INV_MASK = {N_LINES{1'b1}} << INV_BASE;

  logic                    leg_q, ext_a, ext_b;
  logic [N_CH-1:0]         held, pulse, msg_fire;
  logic [N_CH-1:0][RW-1:0] route_eff;
  msg_t [N_CH-1:0]         desc;
  msg_t                    msg;
  logic [N_LINES-1:0]      lines;

  tmr_irq_legacy u_legacy (
    .clk_i(clk_i), .rst_ni(rst_ni), .legacy_i(legacy_i), .pit_i(pit_i),
    .rtc_i(rtc_i), .legacy_o(leg_q), .ext_a_o(ext_a), .ext_b_o(ext_b),
    .pit_en_o(pit_en_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign desc[c] = '{addr: ch_msg_desc_i[c][63:32], data: ch_msg_desc_i[c][31:0]};
    tmr_irq_chan #(
      .RW(RW), .LEG_EN(c < 2), .LEG_ROUTE(c == 0 ? LEG_LINE_A : LEG_LINE_B)
    ) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .legacy_i(leg_q),
      .fire_i(fire_i[c]), .clear_i(clear_i[c]), .en_i(ch_en_i[c]),
      .level_i(ch_level_i[c]), .msg_en_i(ch_msg_en_i[c]), .route_i(ch_route_i[c]),
      .held_o(held[c]), .pulse_o(pulse[c]), .msg_fire_o(msg_fire[c]),
      .route_eff_o(route_eff[c])
    );
  end

  tmr_irq_msg_arb #(.N_CH(N_CH)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(msg_fire), .desc_i(desc),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o), .msg_o(msg)
  );

  always_comb begin
    lines = '0;
    for (int c = 0; c < N_CH; c++)
      if (held[c] || pulse[c]) lines[route_eff[c]] = 1'b1;
    lines[LEG_LINE_A] = lines[LEG_LINE_A] | ext_a;
    lines[LEG_LINE_B] = lines[LEG_LINE_B] | ext_b;
  end

  assign irq_o      = lines ^ INV_MASK;
  assign status_o   = held;
  assign msg_addr_o = msg.addr;
  assign msg_data_o = msg.data;

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (irq_o == INV_MASK && !msg_valid_o));
endmodule

// File: tb/tmr_irq_router_bench.sv
`timescale 1ns/1ps
module tmr_irq_router_bench;
  localparam int NC = 4;
  localparam logic [31:0] IDLE = 32'hFFFF0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic glb_en = 0, legacy = 0, pit = 0, rtc = 0, ready = 0;
  logic [NC-1:0] fire = '0, clr = '0, en = '0, level = '0, msg_en = '0;
  logic [NC-1:0][4:0]  route = '0;
  logic [NC-1:0][63:0] desc = '0;
  logic [31:0] irq, maddr, mdata;
  logic [NC-1:0] status;
  logic pit_en, mvalid;

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  always #10 clk = ~clk;

  tmr_irq_router u_tmr_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .legacy_i(legacy),
    .fire_i(fire), .clear_i(clr), .ch_en_i(en), .ch_level_i(level),
    .ch_msg_en_i(msg_en), .ch_route_i(route), .ch_msg_desc_i(desc),
    .pit_i(pit), .rtc_i(rtc), .msg_ready_i(ready), .irq_o(irq),
    .status_o(status), .pit_en_o(pit_en), .msg_valid_o(mvalid),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  // behavioural reference model
  bit m_st[NC], m_pl[NC], m_mq[NC], m_pend[NC];
  bit m_mv, m_leg, m_rtc, m_pprev, m_ppass;
  logic [31:0] m_ma, m_md;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_st[c]) begin m_st[c] = 0; m_pl[c] = 0; m_mq[c] = 0; m_pend[c] = 0; end
      m_mv = 0; m_leg = 0; m_rtc = 0; m_pprev = 0; m_ppass = 0; m_ma = 0; m_md = 0;
      started = 1;
    end else begin
      int g;
      bit can;
      g = -1;
      for (int c = NC - 1; c >= 0; c--) if (m_pend[c]) g = c;
      can = !m_mv || ready;
      if (can) begin
        if (g >= 0) begin m_mv = 1; m_ma = desc[g][63:32]; m_md = desc[g][31:0]; m_pend[g] = 0; end
        else m_mv = 0;
      end
      for (int c = 0; c < NC; c++) begin
        bit act, tk;
        act = en[c] && glb_en;
        tk  = fire[c] && act && !clr[c];
        if (tk && msg_en[c]) m_pend[c] = 1;
        m_pl[c] = tk && !msg_en[c] && !level[c];
        if (clr[c] || !act || (msg_en[c] && !m_mq[c])) m_st[c] = 0;
        else if (tk && !msg_en[c]) m_st[c] = level[c];
        m_mq[c] = msg_en[c];
      end
      if (legacy || m_leg) m_ppass = 0;
      else if (pit != m_pprev) m_ppass = pit;
      m_pprev = pit; m_leg = legacy; m_rtc = rtc;
    end
  end

  function automatic logic [31:0] exp_irq();
    logic [31:0] l = '0;
    for (int c = 0; c < NC; c++) begin
      int r;
      r = (c == 0 && m_leg) ? 0 : (c == 1 && m_leg) ? 8 : int'(route[c]);
      if (m_st[c] || m_pl[c]) l[r] = 1'b1;
    end
    if (!m_leg) begin l[0] = l[0] | m_ppass; l[8] = l[8] | m_rtc; end
    return l ^ IDLE;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started && rst_n) begin
    logic [NC-1:0] es;
    for (int c = 0; c < NC; c++) es[c] = m_st[c];
    chk("R5 R6 model lines", 64'(irq), 64'(exp_irq()));
    chk("R2 R4 model status", 64'(status), 64'(es));
    chk("R11 model pit_en", 64'(pit_en), 64'(!m_leg));
    chk("R8 model valid", 64'(mvalid), 64'(m_mv));
    if (m_mv) chk("R7 model msg", {maddr, mdata}, {m_ma, m_md});
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    chk("R1 irq", 64'(irq), 64'(IDLE));
    chk("R1 status", 64'(status), 64'(0));
    chk("R1 valid", 64'(mvalid), 64'(0));
    chk("R1 pit_en", 64'(pit_en), 64'(1));

    glb_en = 1; en = '1;
    // level hold
    level[2] = 1; route[2] = 5;
    fire[2] = 1; cyc(); fire[2] = 0;
    chk("R2 status", 64'(status[2]), 64'(1));
    chk("R2 line5", 64'(irq[5]), 64'(1));
    cyc(3);
    chk("R2 held", 64'(irq[5]), 64'(1));
    clr[2] = 1; cyc(); clr[2] = 0;
    chk("R4 clear status", 64'(status[2]), 64'(0));
    chk("R4 clear line", 64'(irq[5]), 64'(0));

    // edge pulse on inverted line
    level[3] = 0; route[3] = 20;
    fire[3] = 1; cyc(); fire[3] = 0;
    chk("R3 pulse", 64'(irq[20]), 64'(0));
    chk("R3 status", 64'(status[3]), 64'(0));
    cyc();
    chk("R3 one clock", 64'(irq[20]), 64'(1));

    // level on inverted line, channel disable
    level[3] = 1; route[3] = 17;
    fire[3] = 1; cyc(); fire[3] = 0;
    chk("R5 active low", 64'(irq[17]), 64'(0));
    en[3] = 0; cyc(); en[3] = 1;
    chk("R4 ch disable", 64'(status[3]), 64'(0));
    chk("R4 ch disable line", 64'(irq[17]), 64'(1));
    glb_en = 0; fire[3] = 1; cyc(); fire[3] = 0; glb_en = 1;
    chk("R4 fire while off", 64'(status[3]), 64'(0));
    fire[2] = 1; clr[2] = 1; cyc(); fire[2] = 0; clr[2] = 0;
    chk("R4 clear wins", 64'(status[2]), 64'(0));

    // replacement mode routing
    level[1:0] = 2'b11; route[0] = 3; route[1] = 4;
    legacy = 1; rtc = 1; cyc();
    chk("R11 pit_en low", 64'(pit_en), 64'(0));
    chk("R11 rtc masked", 64'(irq[8]), 64'(0));
    fire[1:0] = 2'b11; cyc(); fire = '0;
    chk("R6 ch0 line0", 64'(irq[0]), 64'(1));
    chk("R6 ch1 line8", 64'(irq[8]), 64'(1));
    chk("R6 route ignored", 64'({irq[4], irq[3]}), 64'(0));
    legacy = 0; cyc();
    chk("R11 pit_en high", 64'(pit_en), 64'(1));
    chk("R6 own routes", 64'({irq[4], irq[3]}), 64'(2'b11));
    chk("R11 line0 low", 64'(irq[0]), 64'(0));
    clr[1:0] = 2'b11; cyc(); clr = '0;
    chk("R11 rtc restored", 64'(irq[8]), 64'(1));

    // external pass-through
    rtc = 0; cyc();
    chk("R10 rtc", 64'(irq[8]), 64'(0));
    pit = 1; cyc();
    chk("R10 pit high", 64'(irq[0]), 64'(1));
    pit = 0; cyc();
    chk("R10 pit low", 64'(irq[0]), 64'(0));
    pit = 1; cyc();
    legacy = 1; cyc();
    chk("R11 enter drops line0", 64'(irq[0]), 64'(0));
    legacy = 0; cyc();
    chk("R11 leave keeps line0", 64'(irq[0]), 64'(0));
    pit = 0; cyc(); pit = 1; cyc();
    chk("R10 pit change", 64'(irq[0]), 64'(1));

    // message delivery
    level[2] = 1; route[2] = 5;
    fire[2] = 1; cyc(); fire[2] = 0;
    msg_en[2] = 1; cyc();
    chk("R9 status", 64'(status[2]), 64'(0));
    chk("R9 line", 64'(irq[5]), 64'(0));
    msg_en[1] = 1;
    desc[1] = 64'hA000_0010_D000_0001;
    desc[2] = 64'hA000_0020_D000_0002;
    fire[2:1] = 2'b11; cyc(); fire = '0;
    chk("R7 no status", 64'(status), 64'(0));
    chk("R8 not yet", 64'(mvalid), 64'(0));
    cyc();
    chk("R7 no lines", 64'(irq & 32'h0000_0FFF), 64'(irq[0]));
    chk("R8 lowest first", {maddr, mdata}, 64'hA000_0010_D000_0001);
    chk("R8 valid", 64'(mvalid), 64'(1));
    cyc(2);
    chk("R8 held", {31'd0, mvalid, maddr}, {31'd0, 1'b1, 32'hA000_0010});
    ready = 1; cyc();
    chk("R7 addr data", {maddr, mdata}, 64'hA000_0020_D000_0002);
    cyc();
    chk("R8 drained", 64'(mvalid), 64'(0));

    ready = 0;
    fire[1] = 1; cyc(); fire[1] = 0; cyc();
    fire[2] = 1; cyc(); fire[2] = 0; cyc();
    fire[2] = 1; cyc(); fire[2] = 0;
    ready = 1; cyc();
    chk("R8 second", 64'(maddr), 64'(32'hA000_0020));
    cyc();
    chk("R8 merged", 64'(mvalid), 64'(0));
    ready = 0; cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule